// File: doc/BRIEF.md
# Zero-Address Stack ALU

This block is a 4-bit arithmetic and logic unit joined to a small on-chip expression stack. Instructions name no operands. A binary operation reads the top entry and the entry just below it, removes one entry, and writes its result in place of the top. A unary operation rewrites the top entry where it is. Each operation also updates two condition flags: carry/borrow and branch.

The stack holds eight entries. The unit acts only on clock edges where the machine-cycle enable is high, and that enable is asserted on every second system clock. A push to a full stack, or an operation that needs more entries than the stack holds, leaves the stack and the flags as they were. It sets a sticky error flag that stays set until reset.

Top module: `zstack_alu`

## Requirements
- R1: After the asynchronous active-low reset, depth is 0, tos and nos read 0, and carry, branch, ovf_err and unf_err are all 0.
- R2: On a clock edge where mc_en is low, the opcode is ignored: depth, tos, nos and the flags keep their values.
- R3: PUSH (op 4'h1) places din on top and raises depth by one, and the old top becomes nos. DROP (op 4'h2) removes the top and lowers depth by one. Neither changes carry or branch.
- R4: ADD (4'h3) gives nos+tos and ADDC (4'h4) gives nos+tos+carry. Carry takes the carry out of bit 3, and branch is set when the 4-bit result is zero.
- R5: SUB (4'h5) gives nos-tos and SUBB (4'h6) gives nos-tos-carry. Carry is set when a borrow occurs, and branch is set when the 4-bit result is zero.
- R6: AND (4'h7), OR (4'h8), XOR (4'h9) and the unary NOT (4'hA) set branch when the result is zero and leave carry unchanged.
- R7: SHL (4'hB) and SHR (4'hC) shift the top by one bit and fill the vacated bit with zero. Both carry and branch take the bit shifted out.
- R8: ROL (4'hD) and ROR (4'hE) rotate the top through carry. The old carry enters the vacated bit, and both carry and branch take the bit shifted out.
- R9: A PUSH when depth is 8 changes neither the stack nor depth. It sets ovf_err, which stays set until reset.
- R10: A DROP or unary operation at depth 0, or a binary operation at depth below 2, changes neither the stack nor the flags. It sets unf_err, which stays set until reset.
- R11: A binary operation lowers depth by one. The result becomes tos and the entries below it are kept, so the new nos is the entry that was third from the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable; the unit acts only on edges where it is high |
| op | input | 4 | Operation code |
| din | input | 4 | Value pushed by PUSH |
| tos | output | 4 | Top stack entry |
| nos | output | 4 | Entry just below the top |
| depth | output | 4 | Number of entries on the stack |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag |
| ovf_err | output | 1 | Sticky overflow error |
| unf_err | output | 1 | Sticky underflow error |

## Verification
Addition is tried with and without a carry out, with a wrap to zero, and with a carry-in through ADDC. These cases separate the carry flag from the zero-result branch flag. Subtraction is run with a borrow, without one, with an exact zero, and with SUBB following a borrow, which confirms the operand order and that the borrow is fed back. The shift and rotate sequences start from 1001, so the bit shifted out alternates between 1 and 0; this tells zero fill apart from carry fill and shows branch following the shifted-out bit. Logic operations run while carry is set, which shows that carry is preserved, and a third stack entry shows whether the entries below the result are kept.

// File: rtl/zstack_alu.sv
module zstack_alu #(
  parameter int DW    = 4,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mc_en,
  input  logic [3:0]                   op,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                tos,
  output logic [DW-1:0]                nos,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         carry,
  output logic                         branch,
  output logic                         ovf_err,
  output logic                         unf_err
);
  localparam int PW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [PW-1:0] TWO  = PW'(2);

  localparam logic [3:0] OP_PUSH = 4'h1, OP_DROP = 4'h2,
                         OP_ADD  = 4'h3, OP_ADDC = 4'h4,
                         OP_SUB  = 4'h5, OP_SUBB = 4'h6,
                         OP_AND  = 4'h7, OP_OR   = 4'h8,
                         OP_XOR  = 4'h9, OP_NOT  = 4'hA,
                         OP_SHL  = 4'hB, OP_SHR  = 4'hC,
                         OP_ROL  = 4'hD, OP_ROR  = 4'hE;

  logic [DW-1:0] stk [DEPTH];
  logic [DW-1:0] res;
  logic [DW:0]   sum;
  logic          nc, nb;

  assign tos = stk[0];
  assign nos = stk[1];

  wire is_bin = (op >= OP_ADD) && (op <= OP_XOR);
  wire is_un  = (op >= OP_NOT) && (op <= OP_ROR);

  always_comb begin
    sum = '0;
    res = stk[0];
    nc  = carry;
    nb  = branch;
    case (op)
      OP_ADD:  sum = {1'b0, stk[1]} + {1'b0, stk[0]};
      OP_ADDC: sum = {1'b0, stk[1]} + {1'b0, stk[0]} + {{DW{1'b0}}, carry};
      OP_SUB:  sum = {1'b0, stk[1]} - {1'b0, stk[0]};
      OP_SUBB: sum = {1'b0, stk[1]} - {1'b0, stk[0]} - {{DW{1'b0}}, carry};
      default: sum = '0;
    endcase
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        res = sum[DW-1:0]; nc = sum[DW]; nb = (sum[DW-1:0] == '0);
      end
      OP_AND: begin res = stk[1] & stk[0]; nb = (res == '0); end
      OP_OR:  begin res = stk[1] | stk[0]; nb = (res == '0); end
      OP_XOR: begin res = stk[1] ^ stk[0]; nb = (res == '0); end
      OP_NOT: begin res = ~stk[0];         nb = (res == '0); end
      OP_SHL: begin res = {stk[0][DW-2:0], 1'b0};  nc = stk[0][DW-1]; nb = stk[0][DW-1]; end
      OP_SHR: begin res = {1'b0, stk[0][DW-1:1]};  nc = stk[0][0];    nb = stk[0][0];    end
      OP_ROL: begin res = {stk[0][DW-2:0], carry}; nc = stk[0][DW-1]; nb = stk[0][DW-1]; end
      OP_ROR: begin res = {carry, stk[0][DW-1:1]}; nc = stk[0][0];    nb = stk[0][0];    end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
      depth   <= '0;
      carry   <= 1'b0;
      branch  <= 1'b0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else if (mc_en) begin
      if (op == OP_PUSH) begin
        if (depth == FULL) ovf_err <= 1'b1;
        else begin
          for (int i = DEPTH-1; i > 0; i--) stk[i] <= stk[i-1];
          stk[0] <= din;
          depth  <= depth + 1'b1;
        end
      end else if (op == OP_DROP) begin
        if (depth == '0) unf_err <= 1'b1;
        else begin
          for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
          stk[DEPTH-1] <= '0;
          depth <= depth - 1'b1;
        end
      end else if (is_bin) begin
        if (depth < TWO) unf_err <= 1'b1;
        else begin
          stk[0] <= res;
          for (int i = 1; i < DEPTH-1; i++) stk[i] <= stk[i+1];
          stk[DEPTH-1] <= '0;
          depth  <= depth - 1'b1;
          carry  <= nc;
          branch <= nb;
        end
      end else if (is_un) begin
        if (depth == '0) unf_err <= 1'b1;
        else begin
          stk[0] <= res;
          carry  <= nc;
          branch <= nb;
        end
      end
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  assert_idle_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_en |=> $stable(depth) && $stable(tos) && $stable(carry) && $stable(branch));

  assert_push_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && op == OP_PUSH && depth != FULL |=> depth == $past(depth) + 1'b1 && tos == $past(din));

  assert_add_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && op == OP_ADD && depth >= TWO |=> {carry, tos} == {1'b0, $past(nos)} + {1'b0, $past(tos)});

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && op == OP_PUSH && depth == FULL |=> ovf_err && $stable(depth) && $stable(tos));

  assert_underflow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && is_bin && depth < TWO |=> unf_err && $stable(depth) && $stable(carry));

  assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);

  assert_binary_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && is_bin && depth >= TWO |=> depth == $past(depth) - 1'b1);
endmodule

// File: tb/zstack_alu_test.sv
module zstack_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b0;
  logic [3:0] op = 4'h0;
  logic [3:0] din = 4'h0;
  logic [3:0] tos, nos, depth;
  logic       carry, branch, ovf_err, unf_err;
  int checks = 0;
  int fails  = 0;

  zstack_alu uut (.clk(clk), .rst_n(rst_n), .mc_en(mc_en), .op(op), .din(din),
    .tos(tos), .nos(nos), .depth(depth), .carry(carry), .branch(branch),
    .ovf_err(ovf_err), .unf_err(unf_err));

  always #2 clk = ~clk;
  always @(posedge clk) mc_en <= ~mc_en;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [3:0] o, input logic [3:0] d);
    @(negedge clk);
    while (!mc_en) @(negedge clk);
    op = o; din = d;
    @(negedge clk);
    op = 4'h0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 depth", 8'(depth), 8'h0);
    chk("R1 tos", 8'(tos), 8'h0);
    chk("R1 nos", 8'(nos), 8'h0);
    chk("R1 flags", {4'h0, carry, branch, ovf_err, unf_err}, 8'h0);
  endtask

  task automatic t_push_drop();
    do_reset();
    step(4'h1, 4'h3); step(4'h1, 4'h5);
    chk("R3 push tos", 8'(tos), 8'h5);
    chk("R3 push nos", 8'(nos), 8'h3);
    chk("R3 push depth", 8'(depth), 8'h2);
    step(4'h2, 4'h0);
    chk("R3 drop tos", 8'(tos), 8'h3);
    chk("R3 drop depth/flags", {depth, 2'b0, carry, branch}, {4'h1, 4'h0});
  endtask

  task automatic t_add();
    do_reset();
    step(4'h1, 4'h9); step(4'h1, 4'h8); step(4'h3, 4'h0);
    chk("R4 add 9+8", {3'b0, carry, tos}, {3'b0, 1'b1, 4'h1});
    chk("R4 add branch", 8'(branch), 8'h0);
    step(4'h1, 4'hF); step(4'h4, 4'h0);
    chk("R4 addc 1+F+1", {3'b0, carry, tos}, {3'b0, 1'b1, 4'h1});
    step(4'h1, 4'hF); step(4'h3, 4'h0);
    chk("R4 add wrap zero", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b1, 4'h0});
    step(4'h1, 4'h2); step(4'h3, 4'h0);
    chk("R4 add no carry", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'h2});
  endtask

  task automatic t_sub();
    do_reset();
    step(4'h1, 4'h7); step(4'h1, 4'h2); step(4'h5, 4'h0);
    chk("R5 sub 7-2", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'h5});
    step(4'h1, 4'h5); step(4'h5, 4'h0);
    chk("R5 sub zero", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b1, 4'h0});
    step(4'h1, 4'h1); step(4'h5, 4'h0);
    chk("R5 sub borrow", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b0, 4'hF});
    step(4'h1, 4'h3); step(4'h6, 4'h0);
    chk("R5 subb F-3-1", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'hB});
  endtask

  task automatic t_logic();
    do_reset();
    step(4'h1, 4'h9); step(4'h1, 4'h8); step(4'h3, 4'h0);
    step(4'h1, 4'hA); step(4'h1, 4'h6); step(4'h7, 4'h0);
    chk("R6 and", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b0, 4'h2});
    chk("R11 depth after and", 8'(depth), 8'h2);
    chk("R11 below kept", 8'(nos), 8'h1);
    step(4'h1, 4'h5); step(4'h8, 4'h0);
    chk("R6 or", 8'(tos), 8'h7);
    step(4'h1, 4'h7); step(4'h9, 4'h0);
    chk("R6 xor zero", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b1, 4'h0});
    step(4'hA, 4'h0);
    chk("R6 not", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b0, 4'hF});
    chk("R6 not depth", 8'(depth), 8'h2);
  endtask

  task automatic t_shift();
    do_reset();
    step(4'h1, 4'h9); step(4'hB, 4'h0);
    chk("R7 shl", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b1, 4'h2});
    step(4'hC, 4'h0);
    chk("R7 shr out0", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'h1});
    step(4'hC, 4'h0);
    chk("R7 shr out1", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b1, 4'h0});
  endtask

  task automatic t_rotate();
    do_reset();
    step(4'h1, 4'h9); step(4'hB, 4'h0);
    step(4'hD, 4'h0);
    chk("R8 rol", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'h5});
    step(4'hE, 4'h0);
    chk("R8 ror out1", {2'b0, carry, branch, tos}, {2'b0, 1'b1, 1'b1, 4'h2});
    step(4'hE, 4'h0);
    chk("R8 ror carry in", {2'b0, carry, branch, tos}, {2'b0, 1'b0, 1'b0, 4'h9});
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 8; i++) step(4'h1, 4'(i));
    chk("R9 full depth", 8'(depth), 8'h8);
    chk("R9 no err yet", 8'(ovf_err), 8'h0);
    step(4'h1, 4'h9);
    chk("R9 ovf", {ovf_err, unf_err, 2'b0, depth}, {1'b1, 1'b0, 2'b0, 4'h8});
    chk("R9 tos kept", 8'(tos), 8'h8);
    step(4'h2, 4'h0);
    chk("R9 sticky", 8'(ovf_err), 8'h1);
  endtask

  task automatic t_underflow();
    do_reset();
    step(4'h1, 4'h4); step(4'h3, 4'h0);
    chk("R10 binary at depth1", {unf_err, carry, branch, 1'b0, depth}, {1'b1, 1'b0, 1'b0, 1'b0, 4'h1});
    chk("R10 tos kept", 8'(tos), 8'h4);
    do_reset();
    step(4'h2, 4'h0);
    chk("R10 drop empty", {unf_err, 3'b0, depth}, {1'b1, 3'b0, 4'h0});
    do_reset();
    step(4'hB, 4'h0);
    chk("R10 shift empty", {unf_err, carry, branch, 1'b0, depth}, {1'b1, 3'b0, 4'h0});
    step(4'h1, 4'h6);
    chk("R10 sticky", {unf_err, 3'b0, tos}, {1'b1, 3'b0, 4'h6});
  endtask

  task automatic t_gate();
    do_reset();
    step(4'h1, 4'h6);
    @(negedge clk);
    while (mc_en) @(negedge clk);
    op = 4'h1; din = 4'h3;
    @(negedge clk);
    op = 4'h0;
    @(negedge clk);
    chk("R2 idle edge depth", 8'(depth), 8'h1);
    chk("R2 idle edge tos", 8'(tos), 8'h6);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_push_drop();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_rotate();
    t_overflow();
    t_underflow();
    t_gate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule